// File: doc/BRIEF.md
# Replicated Group Generate Gate

This combinational block merges a run of 2^R bit positions into one group carry-generate term, for use as a high-radix node inside a parallel carry network. Each position i supplies a propagate bit and a generate bit. Position 1 is the least significant and sits at bit 0 of each input vector. The block reports whether the group as a whole generates a carry. Its structure never asks any internal wire to drive more than two gate inputs.

Internally the result is built as a sum of minterms. A suffix-AND network computes, for every position, the AND of the propagate bits of all positions above it. This network has the shape of a doubling prefix network laid out from the top position downward. One row of two-input ANDs then pairs each suffix product with the generate bit of the position just below it, which gives one minterm per position. Finally R rows of 2^R two-input ORs merge the minterms and copy the result at the same time. After the last row there are 2^R identical copies, one for each consumer in the next stage of the carry network. The group propagate is not produced here.

The suffix products, the minterms and the OR rows are kept as named internal vectors so that the fan-out structure can be inspected.

Top module: `repl_group_gen`

## Requirements
- R1: All 2^R bits of `grp_gen_o` always hold the same value.
- R2: Every copy equals the serial recurrence acc = g_i | (p_i & acc), evaluated from position 1 up to position 2^R with acc starting at 0.
- R3: When the generate bit of the top position (bit 2^R-1) is 1, every copy is 1, whatever the propagate bits are.
- R4: When all generate bits are 0, every copy is 0.
- R5: When the propagate bits of positions 2 to 2^R (bits 1 to 2^R-1) are all 1, every copy equals the OR of all generate bits.
- R6: The propagate bit of position 1 (bit 0) has no effect on the output.
- R7: Internal minterm j (bit j-1 of `minterm_w`) equals g_j AND the propagate bits of all positions above j. The top minterm equals the top generate bit.
- R8: Internal suffix product j (bit j-1 of `suffix_w`) equals the AND of the propagate bits of positions j through 2^R.
- R9: The output equals the OR of all minterms.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| prop_i | input | 2^R | Propagate bit of each position; bit 0 is position 1 |
| gen_i | input | 2^R | Generate bit of each position; bit 0 is position 1 |
| grp_gen_o | output | 2^R | Identical copies of the group generate |

## Verification
The bench builds the block twice, with R = 3 (eight positions) and with R = 1 (two positions). Both instances are small enough to cover every combination of propagate and generate bits. With R = 3 the full space of 65,536 input patterns exercises all three OR rows and the repeater paths at the top of the suffix network. With R = 1 the degenerate case of one OR row and a single-stage suffix network is covered. A hand-worked table adds the carry chains that break exactly one position short of the top.

// File: rtl/rgg_pkg.sv
package rgg_pkg;

  // Partner index for suffix level l: position j reaches 2^(l-1) upward.
  function automatic int and_partner(input int j, input int l);
    return j + (1 << (l - 1));
  endfunction

  // Lower-half source of copy k on OR row l.
  function automatic int or_src_lo(input int k, input int l);
    int half;
    half = 1 << (l - 1);
    return (k / (2 * half)) * (2 * half) + (k % half);
  endfunction

  // Upper-half source of copy k on OR row l.
  function automatic int or_src_hi(input int k, input int l);
    return or_src_lo(k, l) + (1 << (l - 1));
  endfunction

endpackage

// File: rtl/rgg_suffix_and.sv
module rgg_suffix_and #(
  parameter int R = 3
) (
  input  logic [(1<<R)-1:0] prop_i,
  output logic [(1<<R)-1:0] suffix_o
);
  import rgg_pkg::*;
  localparam int N = 1 << R;

  logic [R:0][N-1:0] lvl;
  assign lvl[0] = prop_i;

  for (genvar l = 1; l <= R; l++) begin : g_lvl
    for (genvar j = 0; j < N; j++) begin : g_pos
      if (and_partner(j, l) < N) begin : g_and
        assign lvl[l][j] = lvl[l-1][j] & lvl[l-1][and_partner(j, l)];
      end else begin : g_rep
        assign lvl[l][j] = lvl[l-1][j];
      end
    end
  end

  assign suffix_o = lvl[R];
endmodule

// File: rtl/rgg_minterms.sv
module rgg_minterms #(
  parameter int R = 3
) (
  input  logic [(1<<R)-1:0] gen_i,
  input  logic [(1<<R)-1:0] suffix_i,
  output logic [(1<<R)-1:0] minterm_o
);
  localparam int N = 1 << R;

  for (genvar j = 0; j < N; j++) begin : g_mt
    if (j < N - 1) begin : g_and
      assign minterm_o[j] = gen_i[j] & suffix_i[j+1];
    end else begin : g_top
      assign minterm_o[j] = gen_i[j];
    end
  end

  // suffix_i[0] covers position 1 and is consumed by no minterm.
  logic unused_low;
  assign unused_low = suffix_i[0];
endmodule

// File: rtl/rgg_or_fanout.sv
module rgg_or_fanout #(
  parameter int R = 3
) (
  input  logic [(1<<R)-1:0] minterm_i,
  output logic [(1<<R)-1:0] copies_o
);
  import rgg_pkg::*;
  localparam int N = 1 << R;

  logic [R:0][N-1:0] row;
  assign row[0] = minterm_i;

  for (genvar l = 1; l <= R; l++) begin : g_row
    for (genvar k = 0; k < N; k++) begin : g_copy
      assign row[l][k] = row[l-1][or_src_lo(k, l)] | row[l-1][or_src_hi(k, l)];
    end
  end

  assign copies_o = row[R];
endmodule

// File: rtl/repl_group_gen.sv
module repl_group_gen #(
  parameter int R = 3
) (
  input  logic [(1<<R)-1:0] prop_i,
  input  logic [(1<<R)-1:0] gen_i,
  output logic [(1<<R)-1:0] grp_gen_o
);
  localparam int N = 1 << R;

  logic [N-1:0] suffix_w;
  logic [N-1:0] minterm_w;

  rgg_suffix_and #(.R(R)) u_suffix (
    .prop_i  (prop_i),
    .suffix_o(suffix_w)
  );

  rgg_minterms #(.R(R)) u_mint (
    .gen_i    (gen_i),
    .suffix_i (suffix_w),
    .minterm_o(minterm_w)
  );

  rgg_or_fanout #(.R(R)) u_or (
    .minterm_i(minterm_w),
    .copies_o (grp_gen_o)
  );
endmodule

// File: rtl/rgg_check.sv
module rgg_check #(
  parameter int R = 3
) (
  input logic [(1<<R)-1:0] prop_i,
  input logic [(1<<R)-1:0] gen_i,
  input logic [(1<<R)-1:0] grp_gen_o,
  input logic [(1<<R)-1:0] suffix_w,
  input logic [(1<<R)-1:0] minterm_w
);
  localparam int N = 1 << R;

  logic          ripple;
  logic [N-1:0]  exp_suffix;
  logic [N-1:0]  exp_mint;

  always_comb begin
    ripple = 1'b0;
    for (int i = 0; i < N; i++) ripple = gen_i[i] | (prop_i[i] & ripple);
    for (int j = 0; j < N; j++) begin
      exp_suffix[j] = 1'b1;
      for (int i = j; i < N; i++) exp_suffix[j] = exp_suffix[j] & prop_i[i];
    end
    for (int j = 0; j < N; j++) begin
      exp_mint[j] = gen_i[j];
      for (int i = j + 1; i < N; i++) exp_mint[j] = exp_mint[j] & prop_i[i];
    end
  end

  always_comb begin
    assert_copies_agree_R1: assert (grp_gen_o == '0 || grp_gen_o == '1)
      else $error("R1: copies disagree %b", grp_gen_o);
    assert_matches_ripple_R2: assert (grp_gen_o[0] == ripple)
      else $error("R2: output %b vs ripple %b", grp_gen_o[0], ripple);
    assert_top_gen_wins_R3: assert (!gen_i[N-1] || grp_gen_o == '1)
      else $error("R3: top generate not honoured");
    assert_no_gen_zero_R4: assert (gen_i != '0 || grp_gen_o == '0)
      else $error("R4: output set with no generate");
    assert_full_prop_or_R5: assert (!(&prop_i[N-1:1]) || grp_gen_o[0] == |gen_i)
      else $error("R5: full propagate mismatch");
    assert_minterms_R7: assert (minterm_w == exp_mint)
      else $error("R7: minterms %b vs %b", minterm_w, exp_mint);
    assert_suffix_R8: assert (suffix_w == exp_suffix)
      else $error("R8: suffix %b vs %b", suffix_w, exp_suffix);
    assert_or_of_minterms_R9: assert (grp_gen_o[N-1] == |minterm_w)
      else $error("R9: output not OR of minterms");
  end
endmodule

bind repl_group_gen rgg_check #(.R(R)) u_chk (
  .prop_i   (prop_i),
  .gen_i    (gen_i),
  .grp_gen_o(grp_gen_o),
  .suffix_w (suffix_w),
  .minterm_w(minterm_w)
);

// File: tb/repl_group_gen_bench.sv
module repl_group_gen_bench;
  localparam int N8 = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic [N8-1:0] p8, g8, y8;
  logic [1:0]    p2, g2, y2;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  repl_group_gen #(.R(3)) u_repl_group_gen (.prop_i(p8), .gen_i(g8), .grp_gen_o(y8));
  repl_group_gen #(.R(1)) u_repl_group_gen_r1 (.prop_i(p2), .gen_i(g2), .grp_gen_o(y2));

  // {propagate, generate, expected group generate}; bit 0 is position 1.
  localparam logic [16:0] TABLE [10] = '{
    {8'h00, 8'h00, 1'b0},
    {8'h00, 8'h80, 1'b1},
    {8'hFE, 8'h01, 1'b1},
    {8'h7E, 8'h01, 1'b0},
    {8'hFF, 8'h01, 1'b1},
    {8'hE0, 8'h10, 1'b1},
    {8'hC0, 8'h10, 1'b0},
    {8'h00, 8'hFF, 1'b1},
    {8'h00, 8'h7F, 1'b0},
    {8'h80, 8'h40, 1'b1}
  };

  function automatic logic ref8(input logic [N8-1:0] p, input logic [N8-1:0] g);
    logic acc;
    acc = 1'b0;
    for (int i = 0; i < N8; i++) acc = g[i] | (p[i] & acc);
    return acc;
  endfunction

  task automatic chk8(input string req, input logic [N8-1:0] exp);
    n_chk++;
    if (y8 !== exp) begin
      n_fail++;
      $display("FAIL %s: p=%h g=%h actual=%b expected=%b", req, p8, g8, y8, exp);
    end
  endtask

  task automatic drive8(input logic [N8-1:0] p, input logic [N8-1:0] g);
    @(negedge clk);
    p8 = p;
    g8 = g;
    #2;
  endtask

  initial begin
    p8 = '0; g8 = '0; p2 = '0; g2 = '0;
    repeat (2) @(posedge clk);
    rst_n = 1'b1;

    // Idle inputs: all zero (R4)
    drive8('0, '0);
    chk8("R4 idle", '0);

    // Table walk (R2, R3, R5)
    for (int t = 0; t < 10; t++) begin
      drive8(TABLE[t][16:9], TABLE[t][8:1]);
      chk8("R2 table", {N8{TABLE[t][0]}});
    end

    // Exhaustive R=3: all copies vs ripple (R1, R2)
    for (int v = 0; v < 65536; v++) begin
      logic [15:0] vv;
      vv = v[15:0];
      drive8(vv[15:8], vv[7:0]);
      chk8("R1 R2 exhaustive", {N8{ref8(vv[15:8], vv[7:0])}});
    end

    // R3: top generate forces ones
    drive8(8'h00, 8'h80); chk8("R3 top gen", '1);
    drive8(8'h5A, 8'h80); chk8("R3 top gen", '1);

    // R5: full upper propagate gives OR of generates
    drive8(8'hFE, 8'h04); chk8("R5 full prop", '1);
    drive8(8'hFE, 8'h00); chk8("R5 full prop", '0);

    // R6: position-1 propagate ignored
    for (int s = 0; s < 4; s++) begin
      logic [N8-1:0] pa, ga;
      logic [N8-1:0] first;
      pa = 8'hB6 ^ (8'h22 * s[7:0]);
      ga = 8'h03 << s;
      drive8({pa[7:1], 1'b0}, ga);
      first = y8;
      drive8({pa[7:1], 1'b1}, ga);
      chk8("R6 x1 ignored", first);
    end

    // R7, R8, R9 seen at the ports: a single generate with a broken chain
    drive8(8'hF8, 8'h04); chk8("R7 R8 R9 single minterm", '1);
    drive8(8'hF0, 8'h04); chk8("R7 R8 R9 chain break", '0);

    // Exhaustive R=1
    for (int v = 0; v < 16; v++) begin
      logic [3:0] w;
      logic e;
      w = v[3:0];
      @(negedge clk);
      p2 = w[3:2];
      g2 = w[1:0];
      #2;
      e = g2[1] | (p2[1] & g2[0]);
      n_chk++;
      if (y2 !== {2{e}}) begin
        n_fail++;
        $display("FAIL R1 R2 r1: p=%b g=%b actual=%b expected=%b", p2, g2, y2, {2{e}});
      end
    end

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  end
endmodule